// File: doc/BRIEF.md
# Radix-4 Forward State-Metric Recursion Unit

This unit advances the forward state metrics of a 4-state recursive trellis by two trellis steps in each clock cycle. It uses a two-level look-ahead, so each accepted input symbol carries two decoded bits. For each step it receives the branch metrics of every (state, input bit) pair for two consecutive steps. It adds them along each of the sixteen two-step paths and reduces the four paths that end in each state with a tree of two-input max* operators. It also receives the backward metrics at the far node. From these it forms four symbol reliability metrics and derives both bit log-likelihood ratios.

Only the metrics at every second trellis node are kept, in one register bank. A two-state controller tracks block boundaries. The first symbol of a block is recursed from fixed start metrics instead of the stored ones. The last symbol returns the unit to idle, and symbols that arrive while it is idle and do not open a block are dropped.

Top module: `r4_acs_unit`

## Requirements
- R1: While reset is asserted, `busy_o` and `out_valid_o` are 0 and `alpha_o`, `llr_hi_o` and `llr_lo_o` are all zero.
- R2: The controller has two states, IDLE and RUN, and `busy_o` is 1 exactly in RUN. The transition IDLE to RUN is taken on an accepted symbol with `blk_first_i` and without `blk_last_i`. The transition RUN to IDLE is taken on any accepted symbol with `blk_last_i`. A symbol with both flags leaves the unit in IDLE.
- R3: A symbol with `sym_valid_i` high, presented in IDLE without `blk_first_i`, is ignored: `out_valid_o` stays 0 and `alpha_o` and both LLR outputs keep their values.
- R4: A symbol accepted with `blk_first_i` is recursed from start metrics 0 for state 0 and -INIT_GAP for states 1 to 3, and not from the stored metrics. This also holds in the middle of a block.
- R5: State s has bits {s1,s0}. Input bit u moves it to {s0, u^s0^s1}. The branch metric of (s,u) sits at bit offset (2s+u)*BW of a branch-metric port, signed. `gam_a_i` holds the earlier step and `gam_b_i` the later one. The metric of state s sits at offset s*MW of `alpha_o` and `beta_i`, signed.
- R6: One cycle after an accepted symbol, `alpha_o` equals two single-step max* recursions of the starting metrics with `gam_a_i` then `gam_b_i`, minus the resulting state-0 value. State 0 therefore reads 0.
- R7: max*(a,b) = max(a,b) + c, where c is 3 for |a-b| <= 1, 2 for 2..3, 1 for 4..7 and 0 otherwise. With CORR_EN = 0, c is always 0.
- R8: The symbol y = {u0,u1} (u0 = earlier bit) has metric lam(y) = max*(max*(P0,P1), max*(P2,P3)). Here Ps = alpha(s) + gam_a(s,u0) + gam_b(m,u1) + beta(t), with m and t the states reached. `llr_hi_o` = max*(lam2,lam3) - max*(lam0,lam1) and `llr_lo_o` = max*(lam1,lam3) - max*(lam0,lam2). Both update one cycle after an accepted symbol.
- R9: With CORR_EN = 0, both LLRs equal exactly the bit-by-bit max-log LLRs of the two single steps.
- R10: `out_valid_o` is 1 exactly in the cycle after an accepted symbol. Outside those cycles `alpha_o` and the LLR outputs hold.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous reset, active low |
| sym_valid_i | input | 1 | A two-step symbol is presented |
| blk_first_i | input | 1 | Symbol opens a block (start metrics used) |
| blk_last_i | input | 1 | Symbol closes the block |
| gam_a_i | input | 8*BW | Branch metrics of the earlier step, per (state, bit) |
| gam_b_i | input | 8*BW | Branch metrics of the later step, per (state, bit) |
| beta_i | input | 4*MW | Backward metrics at the far node |
| busy_o | output | 1 | Controller is in RUN |
| out_valid_o | output | 1 | New metrics and LLRs are on the outputs |
| alpha_o | output | 4*MW | Stored, rescaled forward metrics |
| llr_hi_o | output | MW+4 | LLR of the earlier bit |
| llr_lo_o | output | MW+4 | LLR of the later bit |

## Verification
A wrong path-to-state pairing or a faulty correction term makes `alpha_o` differ from the two-step single-step recursion one cycle after the first affected symbol. Because the metric bank feeds back, the error also carries into every later symbol of the block. A wrong symbol mapping or beta index shows the same cycle as a wrong sign or value of one LLR, while `alpha_o` may still agree. A controller fault shows at `busy_o` and `out_valid_o` on the next edge, or as a block that starts from stale metrics rather than the start values.

// File: rtl/r4_acs_pkg.sv
package r4_acs_pkg;

    typedef enum logic [0:0] {
        ST_IDLE = 1'b0,
        ST_RUN  = 1'b1
    } r4_state_e;

    localparam int NUM_STATES = 4;
    localparam int NUM_BRANCH = 2 * NUM_STATES;
    localparam int NUM_PATHS  = NUM_STATES * NUM_STATES;

endpackage

// File: rtl/r4_maxstar.sv
module r4_maxstar #(
    parameter int W       = 14,
    parameter bit CORR_EN = 1'b1
) (
    input  logic signed [W-1:0] a_i,
    input  logic signed [W-1:0] b_i,
    output logic signed [W-1:0] y_o
);
    logic                a_ge;
    logic signed [W-1:0] big;

    assign a_ge = (a_i >= b_i);
    assign big  = a_ge ? a_i : b_i;

    generate
        if (CORR_EN) begin : g_lut
            logic [W-1:0] diff;
            logic [1:0]   corr;

            assign diff = a_ge ? W'(a_i - b_i) : W'(b_i - a_i);

            always_comb begin
                if (diff <= W'(1))      corr = 2'd3;
                else if (diff <= W'(3)) corr = 2'd2;
                else if (diff <= W'(7)) corr = 2'd1;
                else                    corr = 2'd0;
            end

            assign y_o = big + $signed({{(W-2){1'b0}}, corr});
        end else begin : g_max
            assign y_o = big;
        end
    endgenerate
endmodule

// File: rtl/r4_path_sum.sv
module r4_path_sum #(
    parameter int MW = 12,
    parameter int BW = 8,
    localparam int PW = MW + 2,
    localparam int YW = MW + 3
) (
    input  logic [4*MW-1:0]  alpha_i,
    input  logic [8*BW-1:0]  gam_a_i,
    input  logic [8*BW-1:0]  gam_b_i,
    input  logic [4*MW-1:0]  beta_i,
    output logic [16*PW-1:0] path_o,
    output logic [16*YW-1:0] full_o
);
    logic signed [MW-1:0] alpha_s [4];
    logic signed [MW-1:0] beta_s  [4];
    logic signed [BW-1:0] ga_s    [8];
    logic signed [BW-1:0] gb_s    [8];

    generate
        for (genvar k = 0; k < 4; k++) begin : g_unpack_st
            assign alpha_s[k] = alpha_i[k*MW +: MW];
            assign beta_s[k]  = beta_i[k*MW +: MW];
        end
        for (genvar k = 0; k < 8; k++) begin : g_unpack_br
            assign ga_s[k] = gam_a_i[k*BW +: BW];
            assign gb_s[k] = gam_b_i[k*BW +: BW];
        end

        for (genvar s = 0; s < 4; s++) begin : g_src
            for (genvar y = 0; y < 4; y++) begin : g_sym
                localparam int U0 = (y >> 1) & 1;
                localparam int U1 = y & 1;
                localparam int S0 = s & 1;
                localparam int S1 = (s >> 1) & 1;
                localparam int M  = (S0 << 1) | ((U0 ^ S0 ^ S1) & 1);
                localparam int M0 = M & 1;
                localparam int M1 = (M >> 1) & 1;
                localparam int T  = (M0 << 1) | ((U1 ^ M0 ^ M1) & 1);

                logic signed [PW-1:0] p;

                assign p = PW'(alpha_s[s]) + PW'(ga_s[s*2+U0]) + PW'(gb_s[M*2+U1]);
                assign path_o[(s*4+y)*PW +: PW] = p;
                assign full_o[(s*4+y)*YW +: YW] = YW'(p) + YW'(beta_s[T]);
            end
        end
    endgenerate
endmodule

// File: rtl/r4_acs.sv
module r4_acs #(
    parameter int MW      = 12,
    parameter bit CORR_EN = 1'b1,
    localparam int PW = MW + 2
) (
    input  logic [16*PW-1:0] path_i,
    output logic [4*MW-1:0]  alpha_o
);
    logic signed [PW-1:0] raw [4];

    generate
        for (genvar t = 0; t < 4; t++) begin : g_dst
            logic signed [PW-1:0] leaf [4];
            logic signed [PW-1:0] mid_lo;
            logic signed [PW-1:0] mid_hi;

            // leaves 0,1 share one middle state, leaves 2,3 the other
            for (genvar j = 0; j < 4; j++) begin : g_leaf
                localparam int SJ = ((j & 1) << 1) | ((j >> 1) & 1);
                localparam int U0 = ((t >> 1) ^ (j >> 1) ^ j) & 1;
                localparam int U1 = (t ^ (t >> 1) ^ (j >> 1)) & 1;
                assign leaf[j] = path_i[(SJ*4 + U0*2 + U1)*PW +: PW];
            end

            r4_maxstar #(.W(PW), .CORR_EN(CORR_EN)) u_ms_lo (
                .a_i(leaf[0]), .b_i(leaf[1]), .y_o(mid_lo));
            r4_maxstar #(.W(PW), .CORR_EN(CORR_EN)) u_ms_hi (
                .a_i(leaf[2]), .b_i(leaf[3]), .y_o(mid_hi));
            r4_maxstar #(.W(PW), .CORR_EN(CORR_EN)) u_ms_top (
                .a_i(mid_lo), .b_i(mid_hi), .y_o(raw[t]));

            assign alpha_o[t*MW +: MW] = MW'(raw[t] - raw[0]);
        end
    endgenerate
endmodule

// File: rtl/r4_llr.sv
module r4_llr #(
    parameter int MW      = 12,
    parameter bit CORR_EN = 1'b1,
    localparam int YW = MW + 3,
    localparam int LW = MW + 4
) (
    input  logic [16*YW-1:0] full_i,
    output logic [LW-1:0]    llr_hi_o,
    output logic [LW-1:0]    llr_lo_o
);
    logic signed [YW-1:0] lam [4];
    logic signed [YW-1:0] hi_one, hi_zero, lo_one, lo_zero;

    generate
        for (genvar y = 0; y < 4; y++) begin : g_symm
            logic signed [YW-1:0] leaf [4];
            logic signed [YW-1:0] mid_lo;
            logic signed [YW-1:0] mid_hi;

            for (genvar s = 0; s < 4; s++) begin : g_leaf
                assign leaf[s] = full_i[(s*4+y)*YW +: YW];
            end

            r4_maxstar #(.W(YW), .CORR_EN(CORR_EN)) u_ms_lo (
                .a_i(leaf[0]), .b_i(leaf[1]), .y_o(mid_lo));
            r4_maxstar #(.W(YW), .CORR_EN(CORR_EN)) u_ms_hi (
                .a_i(leaf[2]), .b_i(leaf[3]), .y_o(mid_hi));
            r4_maxstar #(.W(YW), .CORR_EN(CORR_EN)) u_ms_top (
                .a_i(mid_lo), .b_i(mid_hi), .y_o(lam[y]));
        end
    endgenerate

    r4_maxstar #(.W(YW), .CORR_EN(CORR_EN)) u_hi_one (
        .a_i(lam[2]), .b_i(lam[3]), .y_o(hi_one));
    r4_maxstar #(.W(YW), .CORR_EN(CORR_EN)) u_hi_zero (
        .a_i(lam[0]), .b_i(lam[1]), .y_o(hi_zero));
    r4_maxstar #(.W(YW), .CORR_EN(CORR_EN)) u_lo_one (
        .a_i(lam[1]), .b_i(lam[3]), .y_o(lo_one));
    r4_maxstar #(.W(YW), .CORR_EN(CORR_EN)) u_lo_zero (
        .a_i(lam[0]), .b_i(lam[2]), .y_o(lo_zero));

    assign llr_hi_o = LW'(hi_one) - LW'(hi_zero);
    assign llr_lo_o = LW'(lo_one) - LW'(lo_zero);
endmodule

// File: rtl/r4_acs_unit.sv
module r4_acs_unit
    import r4_acs_pkg::*;
#(
    parameter int MW       = 12,
    parameter int BW       = 8,
    parameter int INIT_GAP = 64,
    parameter bit CORR_EN  = 1'b1,
    localparam int LW = MW + 4
) (
    input  logic            clk,
    input  logic            rst_n,
    input  logic            sym_valid_i,
    input  logic            blk_first_i,
    input  logic            blk_last_i,
    input  logic [8*BW-1:0] gam_a_i,
    input  logic [8*BW-1:0] gam_b_i,
    input  logic [4*MW-1:0] beta_i,
    output logic            busy_o,
    output logic            out_valid_o,
    output logic [4*MW-1:0] alpha_o,
    output logic [LW-1:0]   llr_hi_o,
    output logic [LW-1:0]   llr_lo_o
);
    localparam int PW = MW + 2;
    localparam int YW = MW + 3;
    localparam logic [4*MW-1:0] START_METRICS =
        {{3{MW'(-INIT_GAP)}}, MW'(0)};

    r4_state_e st_q, st_d;
    logic            accept;
    logic [4*MW-1:0] alpha_q, alpha_src, alpha_new;
    logic [LW-1:0]   llr_hi_q, llr_lo_q, llr_hi_w, llr_lo_w;
    logic            valid_q;
    logic [16*PW-1:0] path_w;
    logic [16*YW-1:0] full_w;

    assign accept    = sym_valid_i && ((st_q == ST_RUN) || blk_first_i);
    assign alpha_src = blk_first_i ? START_METRICS : alpha_q;

    // next-state logic
    always_comb begin
        st_d = st_q;
        unique case (st_q)
            ST_IDLE: if (sym_valid_i && blk_first_i)
                         st_d = blk_last_i ? ST_IDLE : ST_RUN;
            ST_RUN:  if (sym_valid_i && blk_last_i)
                         st_d = ST_IDLE;
            default: st_d = ST_IDLE;
        endcase
    end

    // state register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= ST_IDLE;
        else        st_q <= st_d;
    end

    r4_path_sum #(.MW(MW), .BW(BW)) u_paths (
        .alpha_i (alpha_src),
        .gam_a_i (gam_a_i),
        .gam_b_i (gam_b_i),
        .beta_i  (beta_i),
        .path_o  (path_w),
        .full_o  (full_w)
    );

    r4_acs #(.MW(MW), .CORR_EN(CORR_EN)) u_acs (
        .path_i  (path_w),
        .alpha_o (alpha_new)
    );

    r4_llr #(.MW(MW), .CORR_EN(CORR_EN)) u_llr (
        .full_i   (full_w),
        .llr_hi_o (llr_hi_w),
        .llr_lo_o (llr_lo_w)
    );

    // output / metric-bank register
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            valid_q  <= 1'b0;
            alpha_q  <= '0;
            llr_hi_q <= '0;
            llr_lo_q <= '0;
        end else begin
            valid_q <= accept;
            if (accept) begin
                alpha_q  <= alpha_new;
                llr_hi_q <= llr_hi_w;
                llr_lo_q <= llr_lo_w;
            end
        end
    end

    assign busy_o      = (st_q == ST_RUN);
    assign out_valid_o = valid_q;
    assign alpha_o     = alpha_q;
    assign llr_hi_o    = llr_hi_q;
    assign llr_lo_o    = llr_lo_q;
endmodule

// File: rtl/r4_acs_unit_chk.sv
module r4_acs_unit_chk #(
    parameter int MW = 12
) (
    input logic            clk,
    input logic            rst_n,
    input logic            sym_valid_i,
    input logic            blk_first_i,
    input logic            blk_last_i,
    input logic            busy_o,
    input logic            out_valid_o,
    input logic [4*MW-1:0] alpha_o
);
    assert_valid_after_symbol_R10: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> $past(sym_valid_i));

    assert_bank_holds_R10: assert property (@(posedge clk) disable iff (!rst_n)
        !out_valid_o |-> $stable(alpha_o));

    assert_state0_zero_R6: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid_o |-> (alpha_o[MW-1:0] == '0));

    assert_idle_drop_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && sym_valid_i && !blk_first_i) |=> !out_valid_o);

    assert_enter_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid_i && blk_first_i && !blk_last_i) |=> busy_o);

    assert_leave_run_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (sym_valid_i && blk_last_i && (busy_o || blk_first_i)) |=> !busy_o);
endmodule

bind r4_acs_unit r4_acs_unit_chk #(.MW(MW)) u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .sym_valid_i (sym_valid_i),
    .blk_first_i (blk_first_i),
    .blk_last_i  (blk_last_i),
    .busy_o      (busy_o),
    .out_valid_o (out_valid_o),
    .alpha_o     (alpha_o)
);

// File: tb/r4_acs_unit_tb_top.sv
module r4_acs_unit_tb_top;
    localparam int MW  = 12;
    localparam int BW  = 8;
    localparam int LW  = MW + 4;
    localparam int GAP = 64;
    localparam int NV  = 12;

    // stimulus table: valid, first, last, seed (0 = all-zero ties, -1 = extremes)
    localparam bit T_VALID [NV] = '{1,1,1,1,0,1,1,1,1,1,1,1};
    localparam bit T_FIRST [NV] = '{1,0,0,0,0,0,0,1,0,1,0,1};
    localparam bit T_LAST  [NV] = '{0,0,0,0,0,1,0,0,0,0,0,1};
    localparam int T_SEED  [NV] = '{7,13,0,-1,21,29,33,41,57,63,71,83};

    logic clk = 1'b0;
    always #5 clk = ~clk;

    logic            rst_n;
    logic            sym_valid, blk_first, blk_last;
    logic [8*BW-1:0] gam_a, gam_b;
    logic [4*MW-1:0] beta;
    logic            busy_c, oval_c, busy_m, oval_m;
    logic [4*MW-1:0] alpha_c, alpha_m;
    logic [LW-1:0]   lhi_c, llo_c, lhi_m, llo_m;

    r4_acs_unit #(.MW(MW), .BW(BW), .INIT_GAP(GAP), .CORR_EN(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .sym_valid_i(sym_valid), .blk_first_i(blk_first),
        .blk_last_i(blk_last), .gam_a_i(gam_a), .gam_b_i(gam_b), .beta_i(beta),
        .busy_o(busy_c), .out_valid_o(oval_c), .alpha_o(alpha_c),
        .llr_hi_o(lhi_c), .llr_lo_o(llo_c));

    r4_acs_unit #(.MW(MW), .BW(BW), .INIT_GAP(GAP), .CORR_EN(1'b0)) dut_ml_i (
        .clk(clk), .rst_n(rst_n), .sym_valid_i(sym_valid), .blk_first_i(blk_first),
        .blk_last_i(blk_last), .gam_a_i(gam_a), .gam_b_i(gam_b), .beta_i(beta),
        .busy_o(busy_m), .out_valid_o(oval_m), .alpha_o(alpha_m),
        .llr_hi_o(lhi_m), .llr_lo_o(llo_m));

    int n_cmp = 0;
    int n_bad = 0;
    int ga[8], gb[8], bt[4];
    int ref_c[4], ref_m[4];
    int exp_hi_c = 0, exp_lo_c = 0, exp_hi_m = 0, exp_lo_m = 0;
    bit ref_busy = 1'b0;

    task automatic chk(input string tag, input string what, input int act, input int exp);
        n_cmp++;
        if (act != exp) begin
            n_bad++;
            $display("FAIL %s %s actual=%0d expected=%0d", tag, what, act, exp);
        end
    endtask

    function automatic int ms(input int a, input int b, input bit c);
        int m, d;
        m = (a > b) ? a : b;
        d = (a > b) ? a - b : b - a;
        if (!c)          return m;
        else if (d <= 1) return m + 3;
        else if (d <= 3) return m + 2;
        else if (d <= 7) return m + 1;
        return m;
    endfunction

    function automatic int nsf(input int s, input int u);
        return ((s & 1) << 1) | ((u ^ s ^ (s >> 1)) & 1);
    endfunction

    function automatic int gen(input int seed, input int i);
        if (seed == 0) return 0;
        if (seed < 0)  return (i % 2 == 1) ? 31 : -31;
        return ((seed * 37 + i * 53 + seed * i * 11) % 63) - 31;
    endfunction

    task automatic r2_step(input bit c, input int cur[4], input int g[8], output int nxt[4]);
        for (int m = 0; m < 4; m++) begin
            bit have;
            int v;
            have = 1'b0;
            v = 0;
            for (int s = 0; s < 4; s++) begin
                for (int u = 0; u < 2; u++) begin
                    if (nsf(s, u) == m) begin
                        v = have ? ms(v, cur[s] + g[s*2+u], c) : cur[s] + g[s*2+u];
                        have = 1'b1;
                    end
                end
            end
            nxt[m] = v;
        end
    endtask

    // R6: two single steps, rescaled by state 0
    task automatic ref_alpha(input bit c, input int cur[4], output int nxt[4]);
        int a1[4], a2[4];
        r2_step(c, cur, ga, a1);
        r2_step(c, a1, gb, a2);
        for (int t = 0; t < 4; t++) nxt[t] = a2[t] - a2[0];
    endtask

    // R8: symbol metrics, tree over start states 0..3
    task automatic ref_sym_llr(input int cur[4], output int hi, output int lo);
        int lam[4];
        for (int y = 0; y < 4; y++) begin
            int p[4];
            for (int s = 0; s < 4; s++) begin
                int m, t;
                m = nsf(s, y >> 1);
                t = nsf(m, y & 1);
                p[s] = cur[s] + ga[s*2 + (y >> 1)] + gb[m*2 + (y & 1)] + bt[t];
            end
            lam[y] = ms(ms(p[0], p[1], 1'b1), ms(p[2], p[3], 1'b1), 1'b1);
        end
        hi = ms(lam[2], lam[3], 1'b1) - ms(lam[0], lam[1], 1'b1);
        lo = ms(lam[1], lam[3], 1'b1) - ms(lam[0], lam[2], 1'b1);
    endtask

    // R9: bit-by-bit max-log LLRs of the two single steps
    task automatic ref_bit_llr(input int cur[4], output int hi, output int lo);
        int a1[4], b1[4];
        int one0, zero0, one1, zero1;
        r2_step(1'b0, cur, ga, a1);
        for (int m = 0; m < 4; m++)
            b1[m] = ms(gb[m*2] + bt[nsf(m, 0)], gb[m*2+1] + bt[nsf(m, 1)], 1'b0);
        one0 = -100000; zero0 = -100000; one1 = -100000; zero1 = -100000;
        for (int s = 0; s < 4; s++) begin
            one0  = ms(one0,  cur[s] + ga[s*2+1] + b1[nsf(s, 1)], 1'b0);
            zero0 = ms(zero0, cur[s] + ga[s*2]   + b1[nsf(s, 0)], 1'b0);
            one1  = ms(one1,  a1[s]  + gb[s*2+1] + bt[nsf(s, 1)], 1'b0);
            zero1 = ms(zero1, a1[s]  + gb[s*2]   + bt[nsf(s, 0)], 1'b0);
        end
        hi = one0 - zero0;
        lo = one1 - zero1;
    endtask

    task automatic load(input int seed);
        for (int i = 0; i < 8; i++) begin
            ga[i] = gen(seed, i);
            gb[i] = gen(seed, i + 8);
            gam_a[i*BW +: BW] = BW'(ga[i]);
            gam_b[i*BW +: BW] = BW'(gb[i]);
        end
        for (int i = 0; i < 4; i++) begin
            bt[i] = gen(seed, i + 16);
            beta[i*MW +: MW] = MW'(bt[i]);
        end
    endtask

    initial begin : watchdog
        repeat (20000) @(posedge clk);
        n_bad++;
        $display("FAIL R10 watchdog actual=running expected=finished");
        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end

    initial begin : main
        rst_n = 1'b0;
        sym_valid = 1'b0; blk_first = 1'b0; blk_last = 1'b0;
        gam_a = '0; gam_b = '0; beta = '0;
        for (int s = 0; s < 4; s++) begin ref_c[s] = 0; ref_m[s] = 0; end
        repeat (3) @(posedge clk);
        #2;
        // R1 reset state
        chk("R1", "busy", int'(busy_c), 0);
        chk("R1", "out_valid", int'(oval_c), 0);
        chk("R1", "alpha", int'(alpha_c != '0), 0);
        chk("R1", "llr", int'((lhi_c != '0) || (llo_c != '0)), 0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int v = 0; v < NV; v++) begin
            bit    acc;
            int    cur_c[4], cur_m[4];
            string tag_a, tag_v, tag_l;
            @(negedge clk);
            load(T_SEED[v]);
            sym_valid = T_VALID[v];
            blk_first = T_FIRST[v];
            blk_last  = T_LAST[v];
            acc = T_VALID[v] && (ref_busy || T_FIRST[v]);
            tag_v = (T_VALID[v] && !ref_busy && !T_FIRST[v]) ? "R3" : "R10";
            tag_a = T_FIRST[v] ? "R4" : ((T_SEED[v] == 13) ? "R5" : "R6");
            tag_l = (T_SEED[v] == 0) ? "R7" : "R8";
            if (acc) begin
                for (int s = 0; s < 4; s++) begin
                    cur_c[s] = T_FIRST[v] ? ((s == 0) ? 0 : -GAP) : ref_c[s];
                    cur_m[s] = T_FIRST[v] ? ((s == 0) ? 0 : -GAP) : ref_m[s];
                end
                ref_sym_llr(cur_c, exp_hi_c, exp_lo_c);
                ref_bit_llr(cur_m, exp_hi_m, exp_lo_m);
                ref_alpha(1'b1, cur_c, ref_c);
                ref_alpha(1'b0, cur_m, ref_m);
                ref_busy = !T_LAST[v];
            end
            @(posedge clk);
            #1;
            chk(tag_v, "out_valid", int'(oval_c), int'(acc));
            chk("R2", "busy", int'(busy_c), int'(ref_busy));
            for (int s = 0; s < 4; s++) begin
                chk(tag_a, "alpha", int'($signed(alpha_c[s*MW +: MW])), ref_c[s]);
                chk("R9", "alpha max-log", int'($signed(alpha_m[s*MW +: MW])), ref_m[s]);
            end
            chk(tag_l, "llr_hi", int'($signed(lhi_c)), exp_hi_c);
            chk(tag_l, "llr_lo", int'($signed(llo_c)), exp_lo_c);
            chk("R9", "llr_hi bitwise", int'($signed(lhi_m)), exp_hi_m);
            chk("R9", "llr_lo bitwise", int'($signed(llo_m)), exp_lo_m);
        end

        // R1: reset in the middle of a block
        @(negedge clk);
        load(91);
        sym_valid = 1'b1; blk_first = 1'b1; blk_last = 1'b0;
        @(negedge clk);
        sym_valid = 1'b0; blk_first = 1'b0;
        chk("R2", "busy before reset", int'(busy_c), 1);
        rst_n = 1'b0;
        #2;
        chk("R1", "busy in reset", int'(busy_c), 0);
        chk("R1", "alpha in reset", int'(alpha_c != '0), 0);
        chk("R1", "llr in reset", int'((lhi_c != '0) || (llo_c != '0)), 0);
        @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);

        $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
        $finish;
    end
endmodule